// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Postscaler

This block is a watchdog that counts on its own low-frequency clock. A fixed binary base counter divides that clock by 128 to form a base tick. A selectable postscaler then multiplies the base period by a power of two, from 1 up to 32,768. When the selected period elapses without a clear, the block raises a one-cycle request. That request is routed as a device reset while the device runs, and as a wake-up while it sleeps.

Software keeps the watchdog quiet by issuing a clear strobe. Several other events also restart the count from zero: entry into sleep, a change of the oscillator frequency selection, a detected clock failure, a device reset, and disabling the block. The three strobes that come from the system clock domain cross into the watchdog domain through toggle synchronizers. The clock-failure flag, the sleep-state level and the software enable pass through two-flop level synchronizers. The hardware enable and the period select are static configuration and are used directly.

The block has no data stream and no valid/ready interface. Every pin is a plain control or status signal.

Top module: `wdt_pscale`

## Requirements
- R1: With period select N (4 bits, value 0 to 15) and the block enabled, `rst_req` goes high for exactly one watchdog clock after 128 × 2^N enabled watchdog clocks counted from zero.
- R2: After each timeout both counts restart from zero, so timeouts repeat every 128 × 2^N watchdog clocks.
- R3: While the synchronized `asleep` level is high, a timeout raises `wake_req` for one cycle instead of `rst_req`.
- R4: A `clr_wdt` pulse sampled on system clock edge k clears both counts at watchdog edge k+3 when the two clocks share one source. A full period then restarts from that edge.
- R5: A `sleep_entry` pulse clears both counts with the same latency as R4.
- R6: An `osc_sel_chg` pulse clears both counts with the same latency as R4.
- R7: A `clk_fail` level first sampled high on edge k clears both counts at edge k+2, and keeps them clear for as long as it stays high.
- R8: A clear that takes effect on the same edge as a timeout wins: no request is issued, and the next timeout falls a full period later.
- R9: The watchdog runs when `hw_en` is high or when the synchronized `sw_en` is high. `sw_en` alone starts counting two edges after it is seen.
- R10: While disabled, both counts are held at zero and no request is issued. Re-enabling always starts a full period.
- R11: While `rst_n` is low both outputs are low. After its release the count starts from zero, whatever count was reached before.
- R12: `rst_req` and `wake_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the strobe inputs |
| wdt_clk | input | 1 | Dedicated low-frequency watchdog clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| hw_en | input | 1 | Static hardware enable from configuration |
| sw_en | input | 1 | Software enable bit |
| per_sel | input | 4 | Postscaler select N, period 128 × 2^N clocks |
| clr_wdt | input | 1 | Clear-watchdog pulse, system domain |
| sleep_entry | input | 1 | Sleep-entry pulse, system domain |
| osc_sel_chg | input | 1 | Oscillator frequency-select change pulse, system domain |
| clk_fail | input | 1 | Clock-failure flag, asynchronous level |
| asleep | input | 1 | Device is in a power-managed sleep state |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench numbers the watchdog clock edges from the release of reset. With N selected, a request is due on edge 128 × 2^N. A strobe sampled on edge k restarts the count at edge k+3, so the next request is due on edge k+3+128 × 2^N. For a clock-failure level the restart edge is k+2, and for `sw_en` alone the first request falls two edges late. Outputs are sampled 2 ns after each rising edge, and the edge number of the first and second pulse on each output is recorded and compared with those computed edges at the end of each scenario.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // strobes that arrive from the system clock domain
  localparam int unsigned SYS_CLR_N = 3;
  typedef enum logic [1:0] {
    SRC_CLRINSN = 2'd0,
    SRC_SLEEP   = 2'd1,
    SRC_OSCSEL  = 2'd2
  } sys_clr_e;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/wdt_pulse_xing.sv
module wdt_pulse_xing (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_out
);
  logic tog;
  logic [2:0] sh;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)        tog <= 1'b0;
    else if (pulse_in) tog <= ~tog;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], tog};
  end

  assign pulse_out = sh[2] ^ sh[1];
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned BASE_W = 7,
  parameter int unsigned PS_W   = 15,
  localparam int unsigned SEL_W = $clog2(PS_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             timeout
);
  logic [BASE_W-1:0] base_cnt;
  logic [PS_W-1:0]   ps_cnt;
  logic [PS_W-1:0]   ps_mask;
  logic              base_done;
  logic              ps_done;

  // bit i of the mask is set when the selected ratio needs postscaler bit i
  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign ps_mask[i] = (SEL_W'(i) < sel);
  end

  assign base_done = &base_cnt;
  assign ps_done   = &(ps_cnt | ~ps_mask);
  assign timeout   = en & ~clr & base_done & ps_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt <= '0;
      ps_cnt   <= '0;
    end else if (!en || clr || timeout) begin
      base_cnt <= '0;
      ps_cnt   <= '0;
    end else begin
      base_cnt <= base_cnt + 1'b1;
      if (base_done) ps_cnt <= ps_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pscale.sv
module wdt_pscale #(
  parameter int unsigned BASE_W = 7,
  parameter int unsigned PS_W   = 15,
  localparam int unsigned SEL_W = $clog2(PS_W + 1)
) (
  input  logic             sys_clk,
  input  logic             wdt_clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] per_sel,
  input  logic             clr_wdt,
  input  logic             sleep_entry,
  input  logic             osc_sel_chg,
  input  logic             clk_fail,
  input  logic             asleep,
  output logic             rst_req,
  output logic             wake_req
);
  import wdt_pkg::*;

  logic [SYS_CLR_N-1:0] sys_strb;
  logic [SYS_CLR_N-1:0] wclr;
  logic [2:0]           lvl_s;
  logic                 sw_s, fail_s, slp_s;
  logic                 en, clr_any, timeout;

  assign sys_strb[int'(SRC_CLRINSN)] = clr_wdt;
  assign sys_strb[int'(SRC_SLEEP)]   = sleep_entry;
  assign sys_strb[int'(SRC_OSCSEL)]  = osc_sel_chg;

  for (genvar i = 0; i < SYS_CLR_N; i++) begin : g_xing
    wdt_pulse_xing u_x (
      .src_clk  (sys_clk),
      .dst_clk  (wdt_clk),
      .rst_n    (rst_n),
      .pulse_in (sys_strb[i]),
      .pulse_out(wclr[i])
    );
  end

  wdt_sync #(.W(3)) u_lvl (
    .clk  (wdt_clk),
    .rst_n(rst_n),
    .d    ({asleep, clk_fail, sw_en}),
    .q    (lvl_s)
  );
  assign sw_s   = lvl_s[0];
  assign fail_s = lvl_s[1];
  assign slp_s  = lvl_s[2];

  assign en      = hw_en | sw_s;
  assign clr_any = (|wclr) | fail_s;

  wdt_core #(.BASE_W(BASE_W), .PS_W(PS_W)) u_core (
    .clk    (wdt_clk),
    .rst_n  (rst_n),
    .en     (en),
    .clr    (clr_any),
    .sel    (per_sel),
    .timeout(timeout)
  );

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= timeout & ~slp_s;
      wake_req <= timeout &  slp_s;
    end
  end
endmodule

// File: rtl/wdt_pscale_chk.sv
module wdt_pscale_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic clr_any,
  input logic slp_s,
  input logic rst_req,
  input logic wake_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R1
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R3
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(slp_s)); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> !(rst_req || wake_req)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(rst_req || wake_req)); // R10
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req)); // R12
endmodule

bind wdt_pscale wdt_pscale_chk u_chk (
  .clk     (wdt_clk),
  .rst_n   (rst_n),
  .en      (en),
  .clr_any (clr_any),
  .slp_s   (slp_s),
  .rst_req (rst_req),
  .wake_req(wake_req)
);

// File: tb/sim_wdt_pscale.sv
`timescale 1ns/1ps
module sim_wdt_pscale;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_en = 1'b0, sw_en = 1'b0;
  logic [3:0] per_sel = '0;
  logic clr_wdt = 1'b0, sleep_entry = 1'b0, osc_sel_chg = 1'b0;
  logic clk_fail = 1'b0, asleep = 1'b0;
  logic rst_req, wake_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  wdt_pscale u0 (
    .sys_clk(clk), .wdt_clk(clk), .rst_n(rst_n),
    .hw_en(hw_en), .sw_en(sw_en), .per_sel(per_sel),
    .clr_wdt(clr_wdt), .sleep_entry(sleep_entry), .osc_sel_chg(osc_sel_chg),
    .clk_fail(clk_fail), .asleep(asleep),
    .rst_req(rst_req), .wake_req(wake_req)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit hw, input bit sw, input int sel, input bit slp);
    @(negedge clk);
    rst_n = 1'b0;
    hw_en = hw; sw_en = sw; per_sel = sel[3:0]; asleep = slp;
    clr_wdt = 0; sleep_entry = 0; osc_sel_chg = 0; clk_fail = 0;
    repeat (3) @(posedge clk);
    #2;
    check(!rst_req && !wake_req, "R11 outputs low in reset", {rst_req, wake_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // kind: 0 none, 1 clr, 2 sleep entry, 3 osc change, 4 clock fail, 5 disable k..k+50
  task automatic drive(input int kind, input logic v);
    case (kind)
      1: clr_wdt = v;
      2: sleep_entry = v;
      3: osc_sel_chg = v;
      4: clk_fail = v;
      default: ;
    endcase
  endtask

  task automatic run_win(input string req, input int n, input int kind, input int k,
                         input bit on_wake, input int exp_a, input int exp_b);
    int fr = 0, sr = 0, cr = 0, fw = 0, sw2 = 0, cw = 0;
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      #2;
      if (rst_req) begin cr++; if (cr == 1) fr = e; else if (cr == 2) sr = e; end
      if (wake_req) begin cw++; if (cw == 1) fw = e; else if (cw == 2) sw2 = e; end
      if (kind >= 1 && kind <= 4) begin
        if (e == k - 1) drive(kind, 1'b1);
        if (e == k)     drive(kind, 1'b0);
      end
      if (kind == 5) begin
        if (e == k)      hw_en = 1'b0;
        if (e == k + 50) hw_en = 1'b1;
      end
    end
    if (on_wake) begin
      check(fw == exp_a, {req, " first wake edge"}, fw, exp_a);
      check(sw2 == exp_b, {req, " second wake edge"}, sw2, exp_b);
      check(cr == 0, {req, " no reset request"}, cr, 0);
    end else begin
      check(fr == exp_a, {req, " first reset edge"}, fr, exp_a);
      check(sr == exp_b, {req, " second reset edge"}, sr, exp_b);
      check(cw == 0, {req, " no wake request"}, cw, 0);
    end
  endtask

  task automatic t_period_n0();   do_reset(1, 0, 0, 0); run_win("R1 R2 N=0", 300, 0, 0, 0, 128, 256); endtask
  task automatic t_period_n2();   do_reset(1, 0, 2, 0); run_win("R1 R2 N=2", 1100, 0, 0, 0, 512, 1024); endtask
  task automatic t_period_n4();   do_reset(1, 0, 4, 0); run_win("R1 N=4", 2100, 0, 0, 0, 2048, 0); endtask
  task automatic t_asleep();      do_reset(1, 0, 0, 1); run_win("R3 asleep wake", 300, 0, 0, 1, 128, 256); endtask
  task automatic t_clr();         do_reset(1, 0, 1, 0); run_win("R4 clear strobe", 500, 1, 200, 0, 459, 0); endtask
  task automatic t_sleep_entry(); do_reset(1, 0, 1, 0); run_win("R5 sleep entry", 400, 2, 100, 0, 359, 0); endtask
  task automatic t_osc_chg();     do_reset(1, 0, 1, 0); run_win("R6 osc select change", 500, 3, 150, 0, 409, 0); endtask
  task automatic t_clk_fail();    do_reset(1, 0, 1, 0); run_win("R7 clock failure", 500, 4, 200, 0, 458, 0); endtask
  task automatic t_clr_collide(); do_reset(1, 0, 1, 0); run_win("R8 clear on timeout", 700, 1, 253, 0, 512, 0); endtask
  task automatic t_off();         do_reset(0, 0, 0, 0); run_win("R9 R10 both enables low", 600, 0, 0, 0, 0, 0); endtask
  task automatic t_sw_only();     do_reset(0, 1, 0, 0); run_win("R9 software enable", 300, 0, 0, 0, 130, 258); endtask
  task automatic t_disable_gap(); do_reset(1, 0, 1, 0); run_win("R10 re-enable full period", 500, 5, 100, 0, 406, 0); endtask
  task automatic t_mid_reset();
    do_reset(1, 0, 1, 0);
    run_win("R11 before reset", 200, 0, 0, 0, 0, 0);
    do_reset(1, 0, 1, 0);
    run_win("R11 after reset", 300, 0, 0, 0, 256, 0);
  endtask

  initial begin
    t_period_n0();
    t_period_n2();
    t_period_n4();
    t_asleep();
    t_clr();
    t_sleep_entry();
    t_osc_chg();
    t_clk_fail();
    t_clr_collide();
    t_off();
    t_sw_only();
    t_disable_gap();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule